// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the slave side of a three-wire serial memory with 64 words of 16 bits each. A host raises chip select (`cs`), clocks bits on `sk` and presents them on `di`. The block samples `di` on each rising `sk` edge. A frame begins with a start bit of 1, followed by a 2-bit opcode and a 6-bit address. Commands that carry data then take 16 data bits, most significant bit first. The block answers on `do_val`, qualified by `do_en`, which stands in for a three-state pin.

The block supports read, single-word write, single-word erase, write-all, erase-all, write-enable and write-disable. It holds a write-protect state that is set at reset. Once a write-type frame is complete, programming starts when `cs` falls. A cycle counter then times the busy period, and nothing can cancel it. While `cs` is high after such a command, `do_val` shows low for busy and high for ready.

The inputs `cs`, `sk` and `di` are taken to be synchronous to `clk` and slower than it. The block detects `sk` and `cs` edges with one register stage. Its outputs are registered.

FSM states:
- `S_IDLE`: waits for a start bit.
- `S_HDR`: shifts in the opcode and the address.
- `S_DATA`: shifts in the 16 data bits.
- `S_ARMED`: the frame is complete and the block waits for `cs` to fall.
- `S_READ`: shifts the word out.
- `S_HOLD`: the command is finished or ignored, and the block waits for `cs` low.
- `S_PROG`: programming is busy.

FSM transitions:
- `S_IDLE` to `S_HDR` on a start bit.
- `S_HDR` to `S_READ`, `S_DATA`, `S_ARMED` or `S_HOLD` on the last address bit, according to the command and the protect state.
- `S_DATA` to `S_ARMED` on the last data bit.
- `S_ARMED` to `S_PROG` when `cs` falls.
- `S_READ` to `S_HOLD` on the edge after the last data bit.
- `S_PROG` to `S_IDLE` when the timer ends.
- `S_HDR`, `S_DATA`, `S_READ` and `S_HOLD` to `S_IDLE` when `cs` is low.

Top module: `tw_eeprom`

## Requirements
- R1: After reset every word reads 0x0000, writes are disabled and `do_en` is low.
- R2: Opcode 10 reads the addressed word. On the rising `sk` edge that samples the last address bit, `do_val` goes to a dummy 0. Each of the next 16 rising edges presents one data bit, bit 15 first. A read works whether writes are enabled or disabled.
- R3: Opcode 01 takes 16 data bits, bit 15 first, and writes them to the addressed word. Memory changes only when `cs` falls after the last data bit.
- R4: Opcode 00 with address bits [5:4] = 01 takes 16 data bits and writes them to all 64 words in one program period.
- R5: Opcode 11 sets the addressed word to 0xFFFF. Opcode 00 with address bits [5:4] = 10 sets all words to 0xFFFF. Neither carries data.
- R6: Opcode 00 with address bits [5:4] = 11 enables writes, and with [5:4] = 00 disables them. While writes are disabled, every write-type command leaves memory unchanged and starts no busy period.
- R7: If `cs` goes low before a frame is complete, the command is dropped with no change to memory. If `cs` goes low during a read, the read ends.
- R8: Programming lasts PROG_CYCLES clock cycles from the fall of `cs`. Neither `cs` nor a start bit can cancel or restart it, and bits received while busy are ignored.
- R9: `do_en` follows `cs` high with one clock of latency and drops one clock after `cs` goes low. After a write-type command, `do_val` reads 0 while busy and 1 when ready, until the next start bit.
- R10: Zeros received before the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial bit clock; `di` is sampled on its rising edge |
| di | input | 1 | Serial command, address and data in |
| do_val | output | 1 | Serial data out, or ready/busy status |
| do_en | output | 1 | High when `do_val` is driven; low stands for high impedance |

## Verification
A wrong header bit count or a wrong decode shows within the same frame. Reads then return shifted or wrong words, and the missing or extra busy status appears a few clocks after `cs` rises again. A protect flag that is set wrongly shows up either as a write that takes effect or as a busy period that never starts. A busy timer that is cut short, or restarted by a stray start bit, shows within one program period: the status reads ready too early, or later writes are lost.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_DATA,
        S_ARMED,
        S_READ,
        S_HOLD,
        S_PROG
    } tw_state_e;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] PRE_DIS  = 2'b00;
    localparam logic [1:0] PRE_ALL  = 2'b01;
    localparam logic [1:0] PRE_ERAL = 2'b10;
    localparam logic [1:0] PRE_EN   = 2'b11;
endpackage

// File: rtl/tw_edge.sv
module tw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    input  logic cs,
    output logic sk_rise,
    output logic cs_fall
);
    logic sk_q, cs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sk;
            cs_q <= cs;
        end
    end

    assign sk_rise = sk & ~sk_q;
    assign cs_fall = ~cs & cs_q;
endmodule

// File: rtl/tw_array.sv
module tw_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_one,
    input  logic              we_all,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (we_all || (we_one && waddr == ADDR_W'(g)))
                mem[g] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int W = $clog2(CYCLES + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= W'(CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom
    import tw_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_val,
    output logic do_en
);
    localparam int HDR_W = 2 + ADDR_W;
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic sk_rise, cs_fall;
    tw_state_e st, st_nx;

    logic [HDR_W-2:0]  hdr;
    logic [HDR_W-1:0]  hdr_full;
    logic [1:0]        op_n, pre_n;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] dreg, rsh, rdata, wdata;
    logic cmd_all, cmd_erase, wen, stat, rd_bit, busy;
    logic we_one, we_all, mem_we;
    logic frame_start, hdr_last, data_last, read_last;

    tw_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sk     (sk),
        .cs     (cs),
        .sk_rise(sk_rise),
        .cs_fall(cs_fall)
    );

    assign hdr_full    = {hdr, di};
    assign op_n        = hdr_full[HDR_W-1 -: 2];
    assign pre_n       = hdr_full[ADDR_W-1 -: 2];
    assign frame_start = cs && sk_rise && di;
    assign hdr_last    = sk_rise && (cnt == CNT_W'(HDR_W - 1));
    assign data_last   = sk_rise && (cnt == CNT_W'(DATA_W - 1));
    assign read_last   = sk_rise && (cnt == CNT_W'(DATA_W));

    assign we_one = (st == S_ARMED) && cs_fall && !cmd_all;
    assign we_all = (st == S_ARMED) && cs_fall && cmd_all;
    assign mem_we = we_one | we_all;
    assign wdata  = cmd_erase ? '1 : dreg;

    tw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we_one(we_one),
        .we_all(we_all),
        .waddr (addr_q),
        .wdata (wdata),
        .raddr (hdr_full[ADDR_W-1:0]),
        .rdata (rdata)
    );

    tw_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(mem_we),
        .busy (busy)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (frame_start) st_nx = S_HDR;
            S_HDR: begin
                if (!cs) st_nx = S_IDLE;
                else if (hdr_last) begin
                    if (op_n == OP_READ)
                        st_nx = S_READ;
                    else if (op_n == OP_EXT && (pre_n == PRE_EN || pre_n == PRE_DIS))
                        st_nx = S_HOLD;
                    else if (!wen)
                        st_nx = S_HOLD;
                    else if (op_n == OP_WRITE || (op_n == OP_EXT && pre_n == PRE_ALL))
                        st_nx = S_DATA;
                    else
                        st_nx = S_ARMED;
                end
            end
            S_DATA: begin
                if (!cs) st_nx = S_IDLE;
                else if (data_last) st_nx = S_ARMED;
            end
            S_ARMED: if (cs_fall) st_nx = S_PROG;
            S_READ: begin
                if (!cs) st_nx = S_IDLE;
                else if (read_last) st_nx = S_HOLD;
            end
            S_HOLD:  if (!cs) st_nx = S_IDLE;
            S_PROG:  if (!busy) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            hdr       <= '0;
            dreg      <= '0;
            rsh       <= '0;
            addr_q    <= '0;
            cmd_all   <= 1'b0;
            cmd_erase <= 1'b0;
            wen       <= 1'b0;
            stat      <= 1'b0;
            rd_bit    <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: if (frame_start) begin
                    cnt  <= '0;
                    stat <= 1'b0;
                end
                S_HDR: if (sk_rise) begin
                    hdr <= hdr_full[HDR_W-2:0];
                    cnt <= cnt + 1'b1;
                    if (hdr_last) begin
                        cnt       <= '0;
                        addr_q    <= hdr_full[ADDR_W-1:0];
                        cmd_all   <= (op_n == OP_EXT);
                        cmd_erase <= (op_n == OP_ERASE) || (op_n == OP_EXT && pre_n == PRE_ERAL);
                        if (op_n == OP_EXT && pre_n == PRE_EN)  wen <= 1'b1;
                        if (op_n == OP_EXT && pre_n == PRE_DIS) wen <= 1'b0;
                        rsh    <= rdata;
                        rd_bit <= 1'b0;
                    end
                end
                S_DATA: if (sk_rise) begin
                    dreg <= {dreg[DATA_W-2:0], di};
                    cnt  <= cnt + 1'b1;
                end
                S_ARMED: if (cs_fall) stat <= 1'b1;
                S_READ: if (sk_rise) begin
                    rd_bit <= rsh[DATA_W-1];
                    rsh    <= {rsh[DATA_W-2:0], 1'b0};
                    cnt    <= cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            do_en  <= 1'b0;
            do_val <= 1'b1;
        end else begin
            do_en  <= cs && (st == S_READ || st == S_PROG || (st == S_IDLE && stat));
            do_val <= (st == S_READ) ? rd_bit : (st != S_PROG);
        end
    end
endmodule

// File: rtl/tw_eeprom_chk.sv
module tw_eeprom_chk
    import tw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs,
    input logic      do_en,
    input logic      do_val,
    input logic      wen,
    input logic      mem_we,
    input logic      busy,
    input tw_state_e st
);
    AST_PROTECT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !wen |-> !mem_we); // R6
    AST_WRITE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> busy); // R8
    AST_PROG_NOT_CANCELLED: assert property (@(posedge clk) disable iff (!rst_n) (st == S_PROG && busy) |=> (st == S_PROG)); // R8
    AST_DO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !cs |=> !do_en); // R9
    AST_BUSY_READS_LOW: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> !do_val); // R9
endmodule

bind tw_eeprom tw_eeprom_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (cs),
    .do_en (do_en),
    .do_val(do_val),
    .wen   (wen),
    .mem_we(mem_we),
    .busy  (busy),
    .st    (st)
);

// File: tb/tw_eeprom_tb_top.sv
module tw_eeprom_tb_top;
    localparam int PROG = 120;

    localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_EN = 3'd2, K_DS = 3'd3,
                           K_WA = 3'd4, K_ER = 3'd5, K_EA = 3'd6;
    localparam int NVEC = 23;
    localparam logic [24:0] VEC [NVEC] = '{
        {K_RD, 6'd5,  16'h0000},
        {K_WR, 6'd5,  16'h1234},
        {K_RD, 6'd5,  16'h0000},
        {K_EN, 6'd0,  16'h0000},
        {K_WR, 6'd5,  16'hA5C3},
        {K_RD, 6'd5,  16'hA5C3},
        {K_WR, 6'd63, 16'h8001},
        {K_RD, 6'd63, 16'h8001},
        {K_RD, 6'd0,  16'h0000},
        {K_ER, 6'd5,  16'h0000},
        {K_RD, 6'd5,  16'hFFFF},
        {K_WA, 6'd0,  16'h3C5A},
        {K_RD, 6'd0,  16'h3C5A},
        {K_RD, 6'd33, 16'h3C5A},
        {K_RD, 6'd63, 16'h3C5A},
        {K_EA, 6'd0,  16'h0000},
        {K_RD, 6'd17, 16'hFFFF},
        {K_WR, 6'd17, 16'h0F0F},
        {K_DS, 6'd0,  16'h0000},
        {K_WR, 6'd17, 16'h1111},
        {K_ER, 6'd17, 16'h0000},
        {K_RD, 6'd17, 16'h0F0F},
        {K_EN, 6'd0,  16'h0000}
    };

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_val, do_en;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    bit wen_m = 1'b0;

    always #4 clk = ~clk;

    tw_eeprom #(.PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .do_val(do_val), .do_en(do_en)
    );

    task automatic cw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic sk_bit(input logic b);
        di = b; cw(2); sk = 1'b1; cw(4); sk = 1'b0; cw(2);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
    endtask

    task automatic frame(input logic [2:0] k, input logic [5:0] a, input logic [15:0] d);
        sk_bit(1'b1);
        unique case (k)
            K_WR: begin send(2'b01, 2); send(a, 6); send(d, 16); end
            K_ER: begin send(2'b11, 2); send(a, 6); end
            K_WA: begin send(2'b00, 2); send(6'b010000, 6); send(d, 16); end
            K_EA: begin send(2'b00, 2); send(6'b100000, 6); end
            K_EN: begin send(2'b00, 2); send(6'b110000, 6); end
            default: begin send(2'b00, 2); send(6'b000000, 6); end
        endcase
    endtask

    // write-type or control command followed by the status phase
    task automatic do_cmd(input logic [2:0] k, input logic [5:0] a, input logic [15:0] d);
        bit prog;
        prog = wen_m && (k == K_WR || k == K_WA || k == K_ER || k == K_EA);
        cs = 1'b1; cw(2);
        frame(k, a, d);
        cs = 1'b0; cw(2);
        cs = 1'b1; cw(4);
        if (k == K_EN) wen_m = 1'b1;
        if (k == K_DS) wen_m = 1'b0;
        if (prog) begin
            check(do_en && !do_val, "R9 busy status", {do_en, do_val}, 2'b10);
            cw(PROG + 6);
            check(do_en && do_val, "R9 ready status", {do_en, do_val}, 2'b11);
        end else begin
            check(!do_en, "R6 no busy period", do_en, 0);
        end
        cs = 1'b0; cw(3);
    endtask

    task automatic do_read(input logic [5:0] a, input int lead, input logic [15:0] exp, input string req);
        logic [15:0] got;
        cs = 1'b1; cw(2);
        if (lead > 0) send(0, lead);
        sk_bit(1'b1); send(2'b10, 2); send(a, 6);
        check(do_en && !do_val, "R2 dummy zero", {do_en, do_val}, 2'b10);
        for (int i = 15; i >= 0; i--) begin
            sk_bit(1'b0);
            got[i] = do_val;
        end
        check(got == exp, req, got, exp);
        cs = 1'b0; cw(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cw(4); rst_n = 1'b1; cw(2);
        check(!do_en, "R1 reset do_en", do_en, 0);
        cs = 1'b1; cw(3);
        check(!do_en, "R1 do_en idle with cs", do_en, 0);
        cs = 1'b0; cw(3);

        // vector table: R2 R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][24:22] == K_RD)
                do_read(VEC[v][21:16], 0, VEC[v][15:0], "R2/R3/R4/R5/R6 read back");
            else
                do_cmd(VEC[v][24:22], VEC[v][21:16], VEC[v][15:0]);
        end

        // R10: leading zeros before the start bit
        do_read(6'd5, 3, 16'hFFFF, "R10 leading zeros");

        // R7: abort during data shifting
        cs = 1'b1; cw(2);
        sk_bit(1'b1); send(2'b01, 2); send(6'd2, 6); send(10'h155, 10);
        cs = 1'b0; cw(2); cs = 1'b1; cw(4);
        check(!do_en, "R7 aborted write has no busy", do_en, 0);
        cs = 1'b0; cw(3);
        do_read(6'd2, 0, 16'hFFFF, "R7 aborted write no change");

        // R7: abort during a read
        cs = 1'b1; cw(2);
        sk_bit(1'b1); send(2'b10, 2); send(6'd17, 6); send(0, 5);
        cs = 1'b0; cw(2);
        check(!do_en, "R7 read abort releases do", do_en, 0);
        cw(2);
        do_read(6'd17, 0, 16'h0F0F, "R7 read after abort");

        // R8: start bit and zeros while busy are ignored (would decode as write-disable)
        cs = 1'b1; cw(2);
        frame(K_WR, 6'd40, 16'h1357);
        cs = 1'b0; cw(2); cs = 1'b1; cw(4);
        sk_bit(1'b1); send(0, 8);
        check(do_en && !do_val, "R8 still busy after stray bits", {do_en, do_val}, 2'b10);
        cw(60);
        check(do_en && do_val, "R8 ready after period", {do_en, do_val}, 2'b11);
        cs = 1'b0; cw(3);
        do_cmd(K_WR, 6'd41, 16'h2468);
        do_read(6'd41, 0, 16'h2468, "R8 stray start bit ignored");
        do_read(6'd40, 0, 16'h1357, "R8 program not cancelled by cs low");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule